// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a down-counting watchdog with a small register port. Software loads a period value, enables counting, and must service the timer by clearing its time-out status before the count runs out. When the count first runs out, the block latches a time-out status, raises an interrupt if interrupts are enabled, and reloads itself from the period value. If the count runs out a second time while that status is still set, and reset escalation is enabled, the block emits a fixed-length reset request pulse for the system reset controller.

Clearing the status reloads the counter, so a single status write both acknowledges the interrupt and services the watchdog. Writing the period value also restarts the count at once. While the run bit is low the counter holds its value.

The register port has a request, a write strobe, a 2-bit word address and a data bus. Read data is combinational on the address.

Top module: `twostage_wdog`

## Requirements
- R1: After reset the counter and period register read 0xFFFFFFFF, the control register reads 0, status reads 0, and irq_o and rst_req_o are low.
- R2: A write to address 0 (period) stores the value, which reads back from address 0, and loads the counter with the same value on the same clock edge. This takes priority over counting.
- R3: While control bit 0 (run) is 1, the counter (read at address 2) decreases by one per clock. While bit 0 is 0, it holds its value.
- R4: When the counter is running and at 0, the next edge is an expiry: the counter reloads from the period register and status bit 0 (read at address 3) is set.
- R5: irq_o equals status bit 0 AND control bit 1 (interrupt enable). Status bit 0 is set by an expiry even when bit 1 is 0.
- R6: An expiry that occurs while status bit 0 is already set and control bit 2 (reset enable) is 1 drives rst_req_o high for exactly PULSE_LEN cycles, starting at that edge.
- R7: Any write to address 3 clears status bit 0 and reloads the counter from the period register. After a clear, the next expiry only sets the status and gives no reset pulse.
- R8: With control bit 2 at 0, an expiry with status set gives no reset pulse.
- R9: Writing 0 to the period register while running makes the following edge an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | 2 | Word address: 0 period, 1 control, 2 counter, 3 status/clear |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| irq_o | output | 1 | Time-out interrupt |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
The counter is first run with interrupts enabled and the status is left uncleared, so the first and second expiries can be seen as separate events. A clear is then issued part of the way into a period with reset enabled. This separates "second expiry" from "second expiry after a clear", because the latter must give only an interrupt. A run with interrupts masked and reset disabled shows that the status still latches while both outputs stay quiet. A zero period written while running checks the edge case of an expiry on the very next cycle. A long idle stretch with run low shows that the counter holds its value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 3;
  localparam int CTRL_RUN = 0;
  localparam int CTRL_IRQ = 1;
  localparam int CTRL_RST = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD  = 2'd0,
    REG_CTRL  = 2'd1,
    REG_COUNT = 2'd2,
    REG_STAT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [CNT_W-1:0]  load_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              load_wr_o,
  output logic              clr_o,
  output logic [CNT_W-1:0]  rdata_o
);
  logic wr;
  assign wr        = req_i && we_i;
  assign load_wr_o = wr && (reg_addr_e'(addr_i) == REG_LOAD);
  assign clr_o     = wr && (reg_addr_e'(addr_i) == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= LOAD_RST;
      ctrl_o <= '0;
    end else begin
      if (load_wr_o) load_o <= wdata_i;
      if (wr && reg_addr_e'(addr_i) == REG_CTRL) ctrl_o <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_LOAD:  rdata_o = load_o;
      REG_CTRL:  rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_o};
      REG_COUNT: rdata_o = cnt_i;
      default:   rdata_o = {{(CNT_W-1){1'b0}}, flag_i};
    endcase
  end

  // R2: period write lands in the register
  p_load_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr_o |=> load_o == $past(wdata_i));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  // writes and clears take priority over an expiry in the same cycle
  assign expire_o = run_i && (cnt_o == '0) && !load_wr_i && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= LOAD_RST;
    else if (load_wr_i)   cnt_o <= load_val_i;
    else if (reload_i)    cnt_o <= load_i;
    else if (expire_o)    cnt_o <= load_i;
    else if (run_i)       cnt_o <= cnt_o - CNT_W'(1);
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_wr_i && !reload_i) |=> $stable(cnt_o));
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_o == $past(load_i));
  p_load_now_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr_i |=> cnt_o == $past(load_val_i));
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic rst_en_i,
  output logic flag_o,
  output logic rst_req_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] pulse_q;
  logic          fire;

  assign fire      = expire_i && flag_o && rst_en_i;
  assign rst_req_o = (pulse_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (clr_i)         flag_o <= 1'b0;
      else if (expire_i) flag_o <= 1'b1;
      if (fire)                 pulse_q <= PW'(PULSE_LEN);
      else if (pulse_q != '0)   pulse_q <= pulse_q - PW'(1);
    end
  end

  p_rst_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(flag_o && rst_en_i && expire_i));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
  p_no_rst_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_en_i && !rst_req_o) |=> !$rose(rst_req_o));
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PULSE_LEN = 4,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0]  load_q, cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              load_wr, clr, expire, flag;

  wdog_regs #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .flag_i(flag), .load_o(load_q), .ctrl_o(ctrl_q),
    .load_wr_o(load_wr), .clr_o(clr), .rdata_o
  );

  wdog_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk_i, .rst_ni, .run_i(ctrl_q[CTRL_RUN]), .load_wr_i(load_wr),
    .load_val_i(wdata_i), .reload_i(clr), .load_i(load_q),
    .cnt_o(cnt_q), .expire_o(expire)
  );

  wdog_escalate #(.PULSE_LEN(PULSE_LEN)) u_esc (
    .clk_i, .rst_ni, .expire_i(expire), .clr_i(clr),
    .rst_en_i(ctrl_q[CTRL_RST]), .flag_o(flag), .rst_req_o
  );

  assign irq_o = flag && ctrl_q[CTRL_IRQ];

  p_irq_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !ctrl_q[CTRL_IRQ] && !(req_i && we_i)) |=> !irq_o);
endmodule

// File: tb/sim_twostage_wdog.sv
module sim_twostage_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twostage_wdog #(.CNT_W(32), .PULSE_LEN(PULSE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(0, v); chk("R1 period", v, 32'hFFFF_FFFF);
    rd(1, v); chk("R1 ctrl", v, 0);
    rd(3, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst", rst_req, 0);
  endtask

  task automatic t_load_hold();
    logic [31:0] v;
    wr(0, 10);
    rd(2, v); chk("R2 count loaded", v, 10);
    rd(0, v); chk("R2 period readback", v, 10);
    tick(5);
    rd(2, v); chk("R3 hold while stopped", v, 10);
  endtask

  task automatic t_first_expiry();
    logic [31:0] v;
    wr(1, 3);                     // run + irq enable
    tick(3);
    rd(2, v); chk("R3 decrement", v, 7);
    tick(7);
    rd(2, v); chk("R4 at zero", v, 0);
    chk("R5 irq before expiry", irq, 0);
    tick(1);
    rd(2, v); chk("R4 reload", v, 10);
    rd(3, v); chk("R4 status set", v, 1);
    chk("R5 irq raised", irq, 1);
  endtask

  task automatic t_escalate();
    logic [31:0] v;
    wr(3, 0);
    chk("R7 irq cleared", irq, 0);
    rd(2, v); chk("R7 clear reloads", v, 10);
    wr(1, 7);                     // run + irq + reset enable
    tick(10);
    chk("R7 cleared expiry gives irq", irq, 1);
    chk("R7 cleared expiry no reset", rst_req, 0);
    tick(11);
    chk("R6 second expiry reset", rst_req, 1);
    tick(PULSE - 1);
    chk("R6 pulse still high", rst_req, 1);
    tick(1);
    chk("R6 pulse ended", rst_req, 0);
    rd(2, v); chk("R6 counting on", v, 6);
    wr(3, 0);                     // service mid-period
    tick(11);
    chk("R7 serviced no reset", rst_req, 0);
    chk("R7 serviced irq again", irq, 1);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(1, 0);
    wr(3, 0);
    wr(0, 2);
    wr(1, 1);                     // run only
    tick(3);
    rd(3, v); chk("R5 status latches when masked", v, 1);
    chk("R5 irq masked", irq, 0);
    rd(2, v); chk("R4 reload to 2", v, 2);
    tick(3);
    chk("R8 no reset when disabled", rst_req, 0);
    rd(3, v); chk("R8 status kept", v, 1);
  endtask

  task automatic t_zero_load();
    logic [31:0] v;
    wr(1, 0);
    wr(3, 0);
    wr(1, 1);
    wr(0, 0);
    rd(3, v); chk("R9 no status yet", v, 0);
    tick(1);
    rd(3, v); chk("R9 immediate expiry", v, 1);
    rd(2, v); chk("R9 counter at zero", v, 0);
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    t_reset();
    t_load_hold();
    t_first_expiry();
    t_escalate();
    t_masked();
    t_zero_load();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule